// File: doc/BRIEF.md
# Module Stop and Software Reset Controller

This block sits between a host register bus and a set of peripheral modules. For each module it provides a clock enable and an active-high reset. Modules are numbered with a flat index and packed 32 to a group. Each group has five word registers. The first is a stop-control word, where a 1 gates the module clock off. The second is a read-only status word that confirms when a module is really running again. The third and fourth set and clear reset bits. The fifth starts a self-timed reset pulse.

The self-timed pulse holds the selected modules in reset for at least one full period of a slow reference clock. That clock is a free-running input of roughly 32 kHz. The block brings it into its own clock domain through a two-flop synchroniser and times the pulse from its rising edges. The real clock acknowledge from a module is modelled inside the block. Each status bit clears a fixed, parameterised number of cycles after the module's stop bit goes to 0.

The host port is a plain single-cycle register interface. A write is taken on every clock edge where the write enable is high. Read data is a combinational function of the address and the current register state. The bus has no valid/ready handshake and never applies back-pressure. All per-module outputs are plain control levels.

Top module: `modstop_rst_ctrl`

## Requirements
- R1: After reset, every stop bit and every reset bit is 1, except for the modules set in `CRIT_MASK`: their stop and reset bits are 0. Each status bit equals its stop bit.
- R2: Module `i` belongs to group `i/32`, at bit `i%32`. The address is `{group, sel}`, with `sel` in the low 3 bits. The `sel` codes are: 0 stop-control, 1 status, 2 reset-set, 3 reset-clear, 4 reset-pulse. `bus_rdata` reflects the current state in the same cycle.
- R3: A write to stop-control loads all 32 bits of the group. From the next cycle, `mod_clk_en[i]` is the inverse of the module's stop bit, and the register reads back the written value.
- R4: A status bit becomes 1 on the same edge where its stop bit becomes 1. It clears exactly `ACK_DELAY` cycles after the stop bit first reads 0. Writes to the status register are ignored.
- R5: On a write to reset-set, each module whose data bit is 1 is placed into reset. Bits written as 0 leave their modules unchanged. Reading reset-set returns the current reset state, which also drives `mod_rst`.
- R6: On a write to reset-clear, each module whose data bit is 1 is released from reset. Bits written as 0 leave their modules unchanged. Reset-clear always reads as 0.
- R7: A write to reset-pulse places the masked modules into reset and marks them pending; reading reset-pulse returns the pending mask. The synchronised slow clock is the slow input after two flops. A rising edge is seen when that synchronised value is 1 and was 0 one cycle earlier. At the second such edge after the write, all pending modules are released and the pending mask clears.
- R8: A reset-pulse write made while a pulse is pending adds its modules to the pending set and restarts the edge count. A reset-set or reset-clear write to a pending module removes it from the pending set.
- R9: Addresses with `sel` 5 to 7, or with a group of `NUM_GROUPS` or above, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous to `clk` |
| bus_addr | input | ADDR_W | Register address `{group, sel}` |
| bus_we | input | 1 | Write enable, taken on every edge where it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| mod_clk_en | output | NUM_GROUPS*32 | Per-module clock enable |
| mod_rst | output | NUM_GROUPS*32 | Per-module reset, active high |

## Verification
The assertions rely on these input assumptions:
- `slow_clk` is much slower than `clk`, and each of its levels lasts several system cycles, so the synchroniser never drops an edge.
- `ACK_DELAY` is at least 1.
- Address and write data are stable around each sampling edge, and only one register is written per cycle.

The stimulus keeps to these assumptions. The bench toggles the slow clock every 40 system cycles, on the falling edge of `clk`. It makes one register access per cycle, and it changes the bus inputs only away from the rising edge.

// File: rtl/ms_pkg.sv
package ms_pkg;
  localparam int GROUP_W = 32;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_RSET  = 3'd2,
    SEL_RCLR  = 3'd3,
    SEL_PULSE = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ms_slow_edge.sv
module ms_slow_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], slow_in};
  end

  // sync_q[1] is the synchronised level, sync_q[2] is that level one cycle earlier
  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ms_ack_delay.sv
module ms_ack_delay #(
  parameter int N     = 64,
  parameter int DELAY = 4,
  parameter logic [N-1:0] INIT_STOP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stop_cur,
  input  logic [N-1:0] stop_nxt,
  output logic [N-1:0] stat_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);

  for (genvar i = 0; i < N; i++) begin : g_mod
    logic [CW-1:0] cnt_q;
    logic          sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        sts_q <= INIT_STOP[i];
      end else if (stop_nxt[i]) begin
        sts_q <= 1'b1;
        cnt_q <= '0;
      end else if (stop_cur[i]) begin
        cnt_q <= '0;
      end else if (sts_q) begin
        if (cnt_q == CW'(DELAY - 1)) sts_q <= 1'b0;
        else                         cnt_q <= cnt_q + 1'b1;
      end
    end

    assign stat_o[i] = sts_q;

    // R4: a stopped module never reports running
    a_r4_stat_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cur[i] |-> sts_q);
    // R4: acknowledge only after the stop bit has been low for a cycle
    a_r4_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q) |-> (!stop_cur[i] && $past(!stop_cur[i])));
  end
endmodule

// File: rtl/ms_pulse_timer.sv
module ms_pulse_timer #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_i,
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] cancel_i,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] release_o
);
  logic [N-1:0] pend_q;
  logic         phase_q;
  logic         active, start, done;

  assign active    = |pend_q;
  assign start     = |start_i;
  assign done      = active & rise_i & phase_q & ~start;
  assign release_o = done ? pend_q : '0;
  assign pending_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      phase_q <= 1'b0;
    end else if (start) begin
      pend_q  <= (pend_q & ~cancel_i) | start_i;
      phase_q <= 1'b0;
    end else if (done) begin
      pend_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      pend_q <= pend_q & ~cancel_i;
      if (active && rise_i) phase_q <= 1'b1;
    end
  end

  // R7: a release empties the pending set
  a_r7_release_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |=> (pend_q == '0));
  // R8: a new pulse request restarts the edge count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!phase_q && ((pend_q & $past(start_i)) == $past(start_i))));
endmodule

// File: rtl/modstop_rst_ctrl.sv
module modstop_rst_ctrl
  import ms_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int ADDR_W     = 5,
  parameter int ACK_DELAY  = 4,
  parameter logic [NUM_GROUPS*GROUP_W-1:0] CRIT_MASK = 64'h0000_0010_0000_0005
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          slow_clk,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_GROUPS*GROUP_W-1:0] mod_clk_en,
  output logic [NUM_GROUPS*GROUP_W-1:0] mod_rst
);
  localparam int N     = NUM_GROUPS * GROUP_W;
  localparam int GRP_W = ADDR_W - SEL_W;
  localparam int GRP_N = 1 << GRP_W;

  logic [GRP_W-1:0] grp;
  logic [SEL_W-1:0] sel;
  logic [N-1:0] stop_q, stop_nxt, rst_q, rst_nxt;
  logic [N-1:0] set_mask, clr_mask, pulse_mask, release_mask, pend, stat;
  logic [31:0]  rd_grp [GRP_N];
  logic         rise, grp_ok, mapped;

  assign grp    = bus_addr[ADDR_W-1:SEL_W];
  assign sel    = bus_addr[SEL_W-1:0];
  assign grp_ok = (32'(grp) < 32'(NUM_GROUPS));
  assign mapped = grp_ok && (sel <= SEL_PULSE);

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    if (g < NUM_GROUPS) begin : g_live
      logic hit;
      assign hit = bus_we && (grp == GRP_W'(g));
      assign stop_nxt[g*GROUP_W +: GROUP_W] =
        (hit && sel == SEL_STOP) ? bus_wdata : stop_q[g*GROUP_W +: GROUP_W];
      assign set_mask[g*GROUP_W +: GROUP_W]   = (hit && sel == SEL_RSET)  ? bus_wdata : '0;
      assign clr_mask[g*GROUP_W +: GROUP_W]   = (hit && sel == SEL_RCLR)  ? bus_wdata : '0;
      assign pulse_mask[g*GROUP_W +: GROUP_W] = (hit && sel == SEL_PULSE) ? bus_wdata : '0;

      always_comb begin
        case (sel)
          SEL_STOP:  rd_grp[g] = stop_q[g*GROUP_W +: GROUP_W];
          SEL_STAT:  rd_grp[g] = stat[g*GROUP_W +: GROUP_W];
          SEL_RSET:  rd_grp[g] = rst_q[g*GROUP_W +: GROUP_W];
          SEL_PULSE: rd_grp[g] = pend[g*GROUP_W +: GROUP_W];
          default:   rd_grp[g] = '0;
        endcase
      end
    end else begin : g_hole
      assign rd_grp[g] = '0;
    end
  end

  assign bus_rdata = rd_grp[grp];

  ms_slow_edge u_edge (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_clk), .rise_o(rise)
  );

  ms_pulse_timer #(.N(N)) u_pulse (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .start_i(pulse_mask), .cancel_i(set_mask | clr_mask),
    .pending_o(pend), .release_o(release_mask)
  );

  ms_ack_delay #(.N(N), .DELAY(ACK_DELAY), .INIT_STOP(~CRIT_MASK)) u_ack (
    .clk(clk), .rst_n(rst_n), .stop_cur(stop_q), .stop_nxt(stop_nxt), .stat_o(stat)
  );

  assign rst_nxt = ((rst_q & ~release_mask) | set_mask | pulse_mask) & ~clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= ~CRIT_MASK;
      rst_q  <= ~CRIT_MASK;
    end else begin
      stop_q <= stop_nxt;
      rst_q  <= rst_nxt;
    end
  end

  assign mod_clk_en = ~stop_q;
  assign mod_rst    = rst_q;

  // R5: set bits are in reset after the write
  a_r5_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((mod_rst & $past(set_mask)) == $past(set_mask)));
  // R6: cleared bits are out of reset after the write
  a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((mod_rst & $past(clr_mask)) == '0));
  // R9: unmapped writes leave the clock gating alone
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped) |=> $stable(mod_clk_en));
  // R9: unmapped reads return zero
  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));
endmodule

// File: tb/sim_modstop_rst_ctrl.sv
module sim_modstop_rst_ctrl;
  localparam int D = 4;
  localparam logic [63:0] CRIT = 64'h0000_0010_0000_0005;

  logic        clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] mod_clk_en, mod_rst;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  modstop_rst_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
  );

  // slow reference: 80 system cycles per period
  int slow_cnt = 0;
  always @(negedge clk) begin
    slow_cnt++;
    if (slow_cnt == 40) begin slow_cnt = 0; slow_clk = ~slow_clk; end
  end

  // behavioural reference model
  logic [63:0] m_stop, m_sts, m_rst, m_pend;
  int          m_cnt [64];
  bit          m_phase, s1, s2, s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stop = ~CRIT; m_sts = ~CRIT; m_rst = ~CRIT; m_pend = '0;
      m_phase = 0; s1 = 0; s2 = 0; s3 = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      bit          rise, start, done;
      int          wg, ws;
      logic [63:0] nstop, setm, clrm, pulm;
      rise = s2 && !s3; s3 = s2; s2 = s1; s1 = slow_clk;
      wg = int'(bus_addr[4:3]); ws = int'(bus_addr[2:0]);
      nstop = m_stop; setm = '0; clrm = '0; pulm = '0;
      if (bus_we && wg < 2) begin
        if (ws == 0) nstop[wg*32 +: 32] = bus_wdata;
        if (ws == 2) setm[wg*32 +: 32] = bus_wdata;
        if (ws == 3) clrm[wg*32 +: 32] = bus_wdata;
        if (ws == 4) pulm[wg*32 +: 32] = bus_wdata;
      end
      start = (pulm != 0);
      done  = (m_pend != 0) && rise && m_phase && !start;
      for (int i = 0; i < 64; i++) begin
        if (nstop[i]) begin m_sts[i] = 1; m_cnt[i] = 0; end
        else if (m_stop[i]) m_cnt[i] = 0;
        else if (m_sts[i]) begin
          if (m_cnt[i] == D - 1) m_sts[i] = 0; else m_cnt[i]++;
        end
      end
      if (done) m_rst = m_rst & ~m_pend;
      m_rst = (m_rst | setm | pulm) & ~clrm;
      if (start) begin m_pend = m_pend | pulm; m_phase = 0; end
      else if (done) begin m_pend = '0; m_phase = 0; end
      else begin
        if (m_pend != 0 && rise) m_phase = 1;
        m_pend = m_pend & ~(setm | clrm);
      end
      m_stop = nstop;
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    int g = int'(a[4:3]);
    if (g >= 2) return '0;
    case (a[2:0])
      3'd0: return m_stop[g*32 +: 32];
      3'd1: return m_sts[g*32 +: 32];
      3'd2: return m_rst[g*32 +: 32];
      3'd4: return m_pend[g*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every cycle: outputs against the model (R3 gating, R5 reset drive)
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R3 clk_en vs model", mod_clk_en, ~m_stop);
      chk("R5 mod_rst vs model", mod_rst, m_rst);
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; #1;
    v = bus_rdata;
    chk(req, {32'b0, v}, {32'b0, m_read(a)});
  endtask

  initial begin
    logic [31:0] v;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    // R1 reset state, fixed expectations
    rd("R1 stop g0", 5'd0, v);  chk("R1 stop g0 fixed", {32'b0, v}, 64'hFFFF_FFFA);
    rd("R1 stop g1", 5'd8, v);  chk("R1 stop g1 fixed", {32'b0, v}, 64'hFFFF_FFEF);
    rd("R1 stat g1", 5'd9, v);  chk("R1 stat g1 fixed", {32'b0, v}, 64'hFFFF_FFEF);
    rd("R1 rst g0", 5'd2, v);   chk("R1 rst g0 fixed", {32'b0, v}, 64'hFFFF_FFFA);
    chk("R1 clk_en fixed", mod_clk_en, CRIT);
    // R3 and R4: start module 1, watch status clear after D cycles (R2 bit mapping)
    wr(5'd0, 32'hFFFF_FFF8);
    for (int j = 0; j < 6; j++) begin
      rd("R4 stat window", 5'd1, v);
      chk("R4 stat bit1 timing", {63'b0, v[1]}, {63'b0, (j < D)});
    end
    chk("R3 clk_en bit1", {63'b0, mod_clk_en[1]}, 64'd1);
    // R4: stopping sets status at once
    wr(5'd0, 32'hFFFF_FFFA);
    rd("R4 stat on stop", 5'd1, v);
    chk("R4 stat bit1 immediate", {63'b0, v[1]}, 64'd1);
    // R4: status writes ignored
    wr(5'd1, 32'h0);
    rd("R4 stop after stat write", 5'd0, v);
    chk("R4 stop unchanged", {32'b0, v}, 64'hFFFF_FFFA);
    // R5 set, R6 clear
    wr(5'd10, 32'h0000_0010);
    rd("R5 rst g1", 5'd10, v);  chk("R5 rst g1 fixed", {32'b0, v}, 64'hFFFF_FFFF);
    wr(5'd3, 32'h0000_00F0);
    rd("R6 rst g0", 5'd2, v);   chk("R6 rst g0 fixed", {32'b0, v}, 64'hFFFF_FF0A);
    rd("R6 clr reads 0", 5'd3, v); chk("R6 clr zero", {32'b0, v}, 64'h0);
    // R9 unmapped
    wr(5'd16, 32'h0); wr(5'd5, 32'h0); wr(5'd24, 32'h0);
    rd("R9 grp2 read", 5'd16, v); chk("R9 grp2 zero", {32'b0, v}, 64'h0);
    rd("R9 sel5 read", 5'd5, v);  chk("R9 sel5 zero", {32'b0, v}, 64'h0);
    rd("R9 stop g1", 5'd8, v);    chk("R9 stop g1 kept", {32'b0, v}, 64'hFFFF_FFEF);
    // R7 pulse
    wr(5'd3, 32'hFFFF_FFFF);
    wr(5'd4, 32'h0000_0003);
    rd("R7 pending", 5'd4, v); chk("R7 pending fixed", {32'b0, v}, 64'h3);
    t = 0;
    do begin rd("R7 hold", 5'd2, v); t++; end while (v[0] && t < 400);
    chk("R7 held long enough", {63'b0, (t >= 80 && t <= 250)}, 64'd1);
    rd("R7 pending cleared", 5'd4, v); chk("R7 pending zero", {32'b0, v}, 64'h0);
    // R8 merge and restart
    wr(5'd4, 32'h1);
    repeat (60) @(negedge clk);
    wr(5'd4, 32'h4);
    rd("R8 merged", 5'd4, v); chk("R8 merged fixed", {32'b0, v}, 64'h5);
    t = 0;
    do begin rd("R8 hold", 5'd2, v); t++; end while (v[0] && t < 400);
    chk("R8 joint release", {32'b0, v & 32'h5}, 64'h0);
    chk("R8 restarted hold", {63'b0, (t >= 80)}, 64'd1);
    // R8 cancel by clear
    wr(5'd4, 32'h8);
    wr(5'd3, 32'h8);
    rd("R8 cancel pending", 5'd4, v); chk("R8 cancel fixed", {32'b0, v}, 64'h0);
    rd("R8 cancel rst", 5'd2, v);     chk("R8 cancel rst bit3", {63'b0, v[3]}, 64'd0);
    repeat (200) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule